// File: doc/BRIEF.md
# Paged Switch Register Bridge over MDIO

This block lets a host reach the 32-bit internal registers of an Ethernet switch whose only management path is a 16-bit MDIO register interface. The host presents a register address, data and a one-cycle request strobe. The bridge turns each request into a short, ordered series of MDIO commands. The first command selects a page by writing the upper address bits to a fixed page register. The following commands are 16-bit accesses to a PHY address and register number derived from the lower address bits.

Four operations are supported. A read fetches both half-words. A write stores the low half first and then the high half, because some switch registers act on the half that arrives last. A modify reads both halves, clears the masked bits, ORs in the set bits and writes the result back in the same low-then-high order. A debug write sends two plain writes to the debug address and debug data registers of a chosen PHY. The last page written is remembered, and the page write is skipped when a request stays inside that page. The MDIO master that serialises the commands onto the wire sits outside the block and is driven through a start/busy command port.

Top module: `mdio_page_bridge`

## Requirements
- R1: For a register access at address A, the half-word commands go to PHY address 0x10 OR A[8:6]. The low half uses register number A[5:1] and the high half uses A[5:1]+1.
- R2: When the page A[24:9] differs from the cached page, or no page is cached, the bridge first writes that page value to PHY 0x18, register 0, before any half-word command of the request.
- R3: The page write is skipped when A[24:9] equals the page last written since reset. Reset invalidates the cache, so the first register access after reset always writes the page.
- R4: A write (host_wr) sends host_wdata[15:0] to the low register and then host_wdata[31:16] to the high register, in that order.
- R5: A read (host_rd) reads the low register and then the high register. At host_done, host_rdata equals {high, low}.
- R6: A modify (host_mod) reads the low half, then the high half, then writes the low half, then the high half. The value written is (old & ~host_mask) | host_wdata. host_rdata returns the old value.
- R7: A debug write (host_dbg) issues no page write. It writes host_wdata[31:16] to register 0x1D and then host_wdata[15:0] to register 0x1E, both at PHY host_addr[4:0]. It leaves the page cache unchanged.
- R8: Each MDIO command is one single-cycle mdio_start pulse, issued only while mdio_busy is low. The command fields stay stable while mdio_busy is high. A command completes when mdio_busy falls, and mdio_rdata is taken at that point.
- R9: host_done is a one-cycle pulse given once per accepted request, after its final MDIO command completes. It is low after reset.
- R10: While a request is in progress, further request strobes are ignored. Strobes that arrive in the same cycle are resolved by priority: read first, then write, then modify, then debug.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 25 | Switch register address; bits [4:0] give the PHY for a debug write |
| host_wdata | input | 32 | Write data, set bits for modify, or {debug address, debug data} |
| host_mask | input | 32 | Bits to clear in a modify |
| host_rd | input | 1 | Read request strobe |
| host_wr | input | 1 | Write request strobe |
| host_mod | input | 1 | Modify request strobe |
| host_dbg | input | 1 | Debug write request strobe |
| host_rdata | output | 32 | Assembled read value (old value for modify) |
| host_done | output | 1 | One-cycle completion pulse |
| mdio_phy | output | 5 | Command PHY address |
| mdio_reg | output | 5 | Command register number |
| mdio_wdata | output | 16 | Command write data |
| mdio_read | output | 1 | 1 = read command, 0 = write command |
| mdio_start | output | 1 | Command start pulse |
| mdio_busy | input | 1 | MDIO master busy |
| mdio_rdata | input | 16 | Read data from MDIO master, valid when busy falls |

## Verification
The bench drives an MDIO master model that holds a paged half-word memory, and checks the exact command sequence of each request. A first write to page zero, a second write to a different PHY group within the same page, and a write to a distant page separate correct caching from an unconditional or a missing page write. A modify with a mask that covers bits in both halves, read back afterwards, separates a correct merge and ordering from swapped halves or a dropped clear. A debug write followed by an access to the cached page, strobes sent during a busy request, strobes that arrive together, and a reset between two same-page reads cover the remaining requirements.

// File: rtl/mdio_page_bridge_pkg.sv
package mdio_page_bridge_pkg;

   typedef enum logic [1:0] {
      OP_READ   = 2'd0,
      OP_WRITE  = 2'd1,
      OP_MODIFY = 2'd2,
      OP_DEBUG  = 2'd3
   } bridge_op_t;

   typedef enum logic [2:0] {
      STEP_PAGE    = 3'd0,
      STEP_RD_LO   = 3'd1,
      STEP_RD_HI   = 3'd2,
      STEP_WR_LO   = 3'd3,
      STEP_WR_HI   = 3'd4,
      STEP_DBG_ADR = 3'd5,
      STEP_DBG_DAT = 3'd6,
      STEP_END     = 3'd7
   } bridge_step_t;

   // first command of a request; a page miss always starts with the page write
   function automatic bridge_step_t first_step(input bridge_op_t op, input logic page_hit);
      bridge_step_t s;
      if (op == OP_DEBUG)      s = STEP_DBG_ADR;
      else if (!page_hit)      s = STEP_PAGE;
      else if (op == OP_WRITE) s = STEP_WR_LO;
      else                     s = STEP_RD_LO;
      return s;
   endfunction

   // fixed command order of each operation
   function automatic bridge_step_t next_step(input bridge_op_t op, input bridge_step_t s);
      bridge_step_t n;
      case (s)
         STEP_PAGE:    n = (op == OP_WRITE) ? STEP_WR_LO : STEP_RD_LO;
         STEP_RD_LO:   n = STEP_RD_HI;
         STEP_RD_HI:   n = (op == OP_MODIFY) ? STEP_WR_LO : STEP_END;
         STEP_WR_LO:   n = STEP_WR_HI;
         STEP_DBG_ADR: n = STEP_DBG_DAT;
         default:      n = STEP_END;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/mpb_addr_split.sv
module mpb_addr_split #(
   parameter int          WADDR_W  = 24,
   parameter int          PAGE_W   = 16,
   parameter int          PHY_W    = 5,
   parameter int          REG_W    = 5,
   parameter logic [4:0]  PHY_BASE = 5'h10
) (
   input  logic [WADDR_W-1:0] word_addr,
   output logic [PAGE_W-1:0]  page,
   output logic [PHY_W-1:0]   phy,
   output logic [REG_W-1:0]   reg_lo,
   output logic [REG_W-1:0]   reg_hi
);
   localparam int SEL_W = WADDR_W - PAGE_W - REG_W;

   if (SEL_W < 1 || SEL_W > PHY_W) begin : g_bad_sel
      $error("mpb_addr_split: PHY select field width %0d out of range", SEL_W);
   end
   if (PHY_W > 5) begin : g_bad_phy
      $error("mpb_addr_split: PHY_W must not exceed 5");
   end

   logic [SEL_W-1:0] sel;

   always_comb begin
      sel    = word_addr[REG_W +: SEL_W];
      page   = word_addr[WADDR_W-1 -: PAGE_W];
      phy    = PHY_BASE[PHY_W-1:0] | PHY_W'(sel);
      reg_lo = word_addr[REG_W-1:0];
      reg_hi = word_addr[REG_W-1:0] + REG_W'(1);
   end
endmodule

// File: rtl/mpb_page_cache.sv
module mpb_page_cache #(
   parameter int PAGE_W   = 16,
   parameter bit CACHE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [PAGE_W-1:0] load_page,
   input  logic [PAGE_W-1:0] probe_page,
   output logic              hit
);
   if (CACHE_EN) begin : g_cached
      logic              valid_q;
      logic [PAGE_W-1:0] page_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q <= 1'b0;
            page_q  <= '0;
         end else if (load) begin
            valid_q <= 1'b1;
            page_q  <= load_page;
         end
      end

      assign hit = valid_q && (page_q == probe_page);

      AST_HIT_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
         (load && probe_page == load_page) |=> hit); // R3
   end else begin : g_uncached
      assign hit = 1'b0;
   end
endmodule

// File: rtl/mpb_mdio_port.sv
module mpb_mdio_port #(
   parameter int PHY_W = 5,
   parameter int REG_W = 5,
   parameter int HW_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [PHY_W-1:0] go_phy,
   input  logic [REG_W-1:0] go_reg,
   input  logic [HW_W-1:0]  go_wdata,
   input  logic             go_read,
   output logic [PHY_W-1:0] mdio_phy,
   output logic [REG_W-1:0] mdio_reg,
   output logic [HW_W-1:0]  mdio_wdata,
   output logic             mdio_read,
   output logic             mdio_start,
   input  logic             mdio_busy,
   input  logic [HW_W-1:0]  mdio_rdata,
   output logic             fin,
   output logic [HW_W-1:0]  fin_rdata
);
   typedef enum logic [1:0] {P_IDLE, P_ISSUE, P_ACK, P_WAIT} port_st_t;

   port_st_t st_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= P_IDLE;
         mdio_phy   <= '0;
         mdio_reg   <= '0;
         mdio_wdata <= '0;
         mdio_read  <= 1'b0;
      end else begin
         case (st_q)
            P_IDLE: if (go) begin
               mdio_phy   <= go_phy;
               mdio_reg   <= go_reg;
               mdio_wdata <= go_wdata;
               mdio_read  <= go_read;
               st_q       <= P_ISSUE;
            end
            P_ISSUE: if (!mdio_busy) st_q <= P_ACK;
            P_ACK:   if (mdio_busy)  st_q <= P_WAIT;
            P_WAIT:  if (!mdio_busy) st_q <= P_IDLE;
            default: st_q <= P_IDLE;
         endcase
      end
   end

   assign mdio_start = (st_q == P_ISSUE) && !mdio_busy;
   assign fin        = (st_q == P_WAIT) && !mdio_busy;
   assign fin_rdata  = mdio_rdata;

   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_start |=> !mdio_start); // R8
   AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_busy && $past(mdio_busy)) |-> ($stable(mdio_phy) && $stable(mdio_reg)
                                           && $stable(mdio_wdata) && $stable(mdio_read))); // R8
   AST_FIN_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> !mdio_start); // R8
endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
   import mdio_page_bridge_pkg::*;
#(
   parameter int          HW_W        = 16,
   parameter int          PAGE_LSB    = 9,
   parameter int          PAGE_W      = 16,
   parameter int          PHY_W       = 5,
   parameter int          REG_W       = 5,
   parameter logic [4:0]  PHY_BASE    = 5'h10,
   parameter logic [4:0]  PAGE_PHY    = 5'h18,
   parameter logic [4:0]  PAGE_REG    = 5'h00,
   parameter logic [4:0]  DBG_ADR_REG = 5'h1D,
   parameter logic [4:0]  DBG_DAT_REG = 5'h1E,
   parameter bit          CACHE_EN    = 1'b1,
   localparam int         AW          = PAGE_LSB + PAGE_W,
   localparam int         DW          = 2 * HW_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    host_addr,
   input  logic [DW-1:0]    host_wdata,
   input  logic [DW-1:0]    host_mask,
   input  logic             host_rd,
   input  logic             host_wr,
   input  logic             host_mod,
   input  logic             host_dbg,
   output logic [DW-1:0]    host_rdata,
   output logic             host_done,
   output logic [PHY_W-1:0] mdio_phy,
   output logic [REG_W-1:0] mdio_reg,
   output logic [HW_W-1:0]  mdio_wdata,
   output logic             mdio_read,
   output logic             mdio_start,
   input  logic             mdio_busy,
   input  logic [HW_W-1:0]  mdio_rdata
);
   if (PAGE_W > HW_W) begin : g_bad_page
      $error("mdio_page_bridge: page value wider than a half-word");
   end
   if (PHY_W != 5 || REG_W != 5) begin : g_bad_fields
      $error("mdio_page_bridge: MDIO PHY and register fields are 5 bits");
   end

   // address split of the incoming request
   logic [PAGE_W-1:0] req_page;
   logic [PHY_W-1:0]  req_phy;
   logic [REG_W-1:0]  req_reg_lo, req_reg_hi;

   mpb_addr_split #(
      .WADDR_W (AW-1), .PAGE_W(PAGE_W), .PHY_W(PHY_W), .REG_W(REG_W), .PHY_BASE(PHY_BASE)
   ) u_split (
      .word_addr (host_addr[AW-1:1]),
      .page      (req_page),
      .phy       (req_phy),
      .reg_lo    (req_reg_lo),
      .reg_hi    (req_reg_hi)
   );

   // request state
   logic              active_q, launch_q, done_q;
   bridge_op_t        op_q, req_op;
   bridge_step_t      step_q, step_nx;
   logic [PAGE_W-1:0] page_q;
   logic [PHY_W-1:0]  phy_q;
   logic [REG_W-1:0]  reg_lo_q, reg_hi_q;
   logic [DW-1:0]     wdata_q, mask_q, rdata_q;
   logic [HW_W-1:0]   lo_q, hi_q;
   logic              page_hit, accept, req_any;
   logic              port_fin;
   logic [HW_W-1:0]   port_rdata;

   mpb_page_cache #(.PAGE_W(PAGE_W), .CACHE_EN(CACHE_EN)) u_cache (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (port_fin && step_q == STEP_PAGE),
      .load_page  (page_q),
      .probe_page (req_page),
      .hit        (page_hit)
   );

   // fixed priority between simultaneous strobes
   always_comb begin
      if (host_rd)       req_op = OP_READ;
      else if (host_wr)  req_op = OP_WRITE;
      else if (host_mod) req_op = OP_MODIFY;
      else               req_op = OP_DEBUG;
   end

   assign req_any = host_rd | host_wr | host_mod | host_dbg;
   assign accept  = !active_q && req_any;
   assign step_nx = next_step(op_q, step_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         launch_q <= 1'b0;
         done_q   <= 1'b0;
         op_q     <= OP_READ;
         step_q   <= STEP_END;
         page_q   <= '0;
         phy_q    <= '0;
         reg_lo_q <= '0;
         reg_hi_q <= '0;
         wdata_q  <= '0;
         mask_q   <= '0;
         lo_q     <= '0;
         hi_q     <= '0;
         rdata_q  <= '0;
      end else begin
         launch_q <= 1'b0;
         done_q   <= 1'b0;
         if (accept) begin
            active_q <= 1'b1;
            launch_q <= 1'b1;
            op_q     <= req_op;
            step_q   <= first_step(req_op, page_hit);
            page_q   <= req_page;
            phy_q    <= (req_op == OP_DEBUG) ? host_addr[PHY_W-1:0] : req_phy;
            reg_lo_q <= req_reg_lo;
            reg_hi_q <= req_reg_hi;
            wdata_q  <= host_wdata;
            mask_q   <= host_mask;
         end else if (active_q && port_fin) begin
            if (step_q == STEP_RD_LO) lo_q <= port_rdata;
            if (step_q == STEP_RD_HI) begin
               hi_q    <= port_rdata;
               rdata_q <= {port_rdata, lo_q};
            end
            step_q <= step_nx;
            if (step_nx == STEP_END) begin
               active_q <= 1'b0;
               done_q   <= 1'b1;
            end else begin
               launch_q <= 1'b1;
            end
         end
      end
   end

   // command selection for the current step
   logic [DW-1:0]     store_val;
   logic [PHY_W-1:0]  cmd_phy;
   logic [REG_W-1:0]  cmd_reg;
   logic [HW_W-1:0]   cmd_data;
   logic              cmd_read;

   assign store_val = (op_q == OP_MODIFY) ? (({hi_q, lo_q} & ~mask_q) | wdata_q) : wdata_q;

   always_comb begin
      cmd_phy  = phy_q;
      cmd_reg  = reg_lo_q;
      cmd_data = '0;
      cmd_read = 1'b0;
      case (step_q)
         STEP_PAGE: begin
            cmd_phy  = PAGE_PHY[PHY_W-1:0];
            cmd_reg  = PAGE_REG[REG_W-1:0];
            cmd_data = HW_W'(page_q);
         end
         STEP_RD_LO: cmd_read = 1'b1;
         STEP_RD_HI: begin
            cmd_reg  = reg_hi_q;
            cmd_read = 1'b1;
         end
         STEP_WR_LO: cmd_data = store_val[HW_W-1:0];
         STEP_WR_HI: begin
            cmd_reg  = reg_hi_q;
            cmd_data = store_val[DW-1:HW_W];
         end
         STEP_DBG_ADR: begin
            cmd_reg  = DBG_ADR_REG[REG_W-1:0];
            cmd_data = wdata_q[DW-1:HW_W];
         end
         STEP_DBG_DAT: begin
            cmd_reg  = DBG_DAT_REG[REG_W-1:0];
            cmd_data = wdata_q[HW_W-1:0];
         end
         default: ;
      endcase
   end

   mpb_mdio_port #(.PHY_W(PHY_W), .REG_W(REG_W), .HW_W(HW_W)) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (launch_q),
      .go_phy     (cmd_phy),
      .go_reg     (cmd_reg),
      .go_wdata   (cmd_data),
      .go_read    (cmd_read),
      .mdio_phy   (mdio_phy),
      .mdio_reg   (mdio_reg),
      .mdio_wdata (mdio_wdata),
      .mdio_read  (mdio_read),
      .mdio_start (mdio_start),
      .mdio_busy  (mdio_busy),
      .mdio_rdata (mdio_rdata),
      .fin        (port_fin),
      .fin_rdata  (port_rdata)
   );

   assign host_done  = done_q;
   assign host_rdata = rdata_q;

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      host_done |=> !host_done); // R9
   AST_LO_BEFORE_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q == STEP_WR_HI && $past(step_q) != STEP_WR_HI) |-> $past(step_q) == STEP_WR_LO); // R4
   AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && $past(active_q)) |-> ($stable(op_q) && $stable(page_q) && $stable(wdata_q))); // R10
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      host_done |-> !active_q); // R9
endmodule

// File: tb/mdio_page_bridge_tb.sv
module mdio_page_bridge_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int LAT        = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [24:0] host_addr = '0;
   logic [31:0] host_wdata = '0, host_mask = '0;
   logic        host_rd = 0, host_wr = 0, host_mod = 0, host_dbg = 0;
   logic [31:0] host_rdata;
   logic        host_done;
   logic [4:0]  mdio_phy, mdio_reg;
   logic [15:0] mdio_wdata;
   logic        mdio_read, mdio_start;
   logic        m_busy = 1'b0;
   logic [15:0] m_rdata = '0;

   int checks = 0, failures = 0;
   int cycles = 0;

   mdio_page_bridge dut_i (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_mask(host_mask), .host_rd(host_rd), .host_wr(host_wr), .host_mod(host_mod),
      .host_dbg(host_dbg), .host_rdata(host_rdata), .host_done(host_done),
      .mdio_phy(mdio_phy), .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata),
      .mdio_read(mdio_read), .mdio_start(mdio_start), .mdio_busy(m_busy),
      .mdio_rdata(m_rdata)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // MDIO master model with a paged half-word store
   logic [15:0] hw_mem [logic [23:0]];
   logic [15:0] m_page = '0;
   logic [4:0]  c_phy = '0, c_reg = '0;
   logic [15:0] c_dat = '0;
   logic        c_rd = 1'b0;
   int          m_cnt = 0;
   int          start_cnt = 0;
   int          done_cnt = 0;
   logic [4:0]  log_phy [0:255];
   logic [4:0]  log_reg [0:255];
   logic [15:0] log_dat [0:255];
   logic        log_rd  [0:255];
   int          log_n = 0;

   function automatic logic [15:0] hw_get(input logic [23:0] k);
      return hw_mem.exists(k) ? hw_mem[k] : 16'h0000;
   endfunction

   always @(posedge clk) begin
      if (host_done) done_cnt++;
      if (!rst_n) begin
         m_busy <= 1'b0;
         m_cnt  <= 0;
      end else if (!m_busy) begin
         if (mdio_start) begin
            start_cnt++;
            m_busy <= 1'b1;
            m_cnt  <= LAT;
            c_phy  <= mdio_phy;
            c_reg  <= mdio_reg;
            c_dat  <= mdio_wdata;
            c_rd   <= mdio_read;
         end
      end else if (m_cnt > 1) begin
         m_cnt <= m_cnt - 1;
      end else begin
         m_busy <= 1'b0;
         if (log_n < 256) begin
            log_phy[log_n] = c_phy;
            log_reg[log_n] = c_reg;
            log_dat[log_n] = c_rd ? hw_get({m_page, c_phy[2:0], c_reg}) : c_dat;
            log_rd[log_n]  = c_rd;
            log_n++;
         end
         if (c_rd) m_rdata <= hw_get({m_page, c_phy[2:0], c_reg});
         else if (c_phy == 5'h18 && c_reg == 5'h00) m_page = c_dat;
         else hw_mem[{m_page, c_phy[2:0], c_reg}] = c_dat;
      end
   end

   // expected fields from the address rules
   function automatic logic [15:0] e_page(input logic [24:0] a); return a[24:9]; endfunction
   function automatic logic [4:0]  e_phy (input logic [24:0] a); return 5'h10 | {2'b00, a[8:6]}; endfunction
   function automatic logic [4:0]  e_reg (input logic [24:0] a); return a[5:1]; endfunction

   task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_cmd(input string tag, input int idx, input logic [4:0] phy,
                            input logic [4:0] rg, input logic rd, input logic [15:0] dat);
      check_eq({tag, " phy"}, 32'(log_phy[idx]), 32'(phy));
      check_eq({tag, " reg"}, 32'(log_reg[idx]), 32'(rg));
      check_eq({tag, " dir"}, 32'(log_rd[idx]), 32'(rd));
      if (!rd) check_eq({tag, " data"}, 32'(log_dat[idx]), 32'(dat));
   endtask

   // op: 0 read, 1 write, 2 modify, 3 debug
   task automatic run_op(input string tag, input int op, input logic [24:0] a,
                         input logic [31:0] wd, input logic [31:0] mk,
                         output int base, output logic [31:0] rd_val);
      int d0;
      bit got;
      base = log_n;
      d0   = done_cnt;
      got  = 0;
      @(negedge clk);
      host_addr = a; host_wdata = wd; host_mask = mk;
      host_rd = (op == 0); host_wr = (op == 1); host_mod = (op == 2); host_dbg = (op == 3);
      @(negedge clk);
      host_rd = 0; host_wr = 0; host_mod = 0; host_dbg = 0;
      for (int i = 0; i < 400; i++) begin
         if (host_done) begin got = 1; break; end
         @(negedge clk);
      end
      rd_val = host_rdata;
      check_eq({tag, " R9 done seen"}, 32'(got), 32'd1);
      @(negedge clk);
      check_eq({tag, " R9 done one cycle"}, 32'(host_done), 32'd0);
      check_eq({tag, " R9 one done per request"}, 32'(done_cnt - d0), 32'd1);
   endtask

   localparam logic [24:0] A1 = 25'h000_002C;
   localparam logic [24:0] A2 = 25'h000_0068;
   localparam logic [24:0] A3 = 25'h012_3450;

   task automatic t_reset_state();
      check_eq("R9 done low after reset", 32'(host_done), 32'd0);
      check_eq("R8 no start after reset", 32'(mdio_start), 32'd0);
   endtask

   task automatic t_first_write();
      int b; logic [31:0] r;
      run_op("first write", 1, A1, 32'hA5A5_1234, 32'h0, b, r);
      check_eq("R2 three commands", 32'(log_n - b), 32'd3);
      check_cmd("R2 page write", b, 5'h18, 5'h00, 1'b0, e_page(A1));
      check_cmd("R1 R4 low half", b + 1, e_phy(A1), e_reg(A1), 1'b0, 16'h1234);
      check_cmd("R1 R4 high half", b + 2, e_phy(A1), e_reg(A1) + 5'd1, 1'b0, 16'hA5A5);
   endtask

   task automatic t_cached_write();
      int b; logic [31:0] r;
      run_op("cached write", 1, A2, 32'h0BAD_F00D, 32'h0, b, r);
      check_eq("R3 page write skipped", 32'(log_n - b), 32'd2);
      check_cmd("R1 R3 low half", b, e_phy(A2), e_reg(A2), 1'b0, 16'hF00D);
      check_cmd("R1 R3 high half", b + 1, e_phy(A2), e_reg(A2) + 5'd1, 1'b0, 16'h0BAD);
   endtask

   task automatic t_read();
      int b; logic [31:0] r;
      run_op("read A1", 0, A1, 32'h0, 32'h0, b, r);
      check_eq("R5 two reads", 32'(log_n - b), 32'd2);
      check_cmd("R5 low read", b, e_phy(A1), e_reg(A1), 1'b1, 16'h0);
      check_cmd("R5 high read", b + 1, e_phy(A1), e_reg(A1) + 5'd1, 1'b1, 16'h0);
      check_eq("R5 read value", r, 32'hA5A5_1234);
   endtask

   task automatic t_new_page();
      int b; logic [31:0] r;
      run_op("new page write", 1, A3, 32'h7E57_C0DE, 32'h0, b, r);
      check_eq("R2 new page three commands", 32'(log_n - b), 32'd3);
      check_cmd("R2 new page value", b, 5'h18, 5'h00, 1'b0, e_page(A3));
      run_op("new page read", 0, A3, 32'h0, 32'h0, b, r);
      check_eq("R3 same page read cached", 32'(log_n - b), 32'd2);
      check_eq("R5 new page read value", r, 32'h7E57_C0DE);
   endtask

   task automatic t_modify();
      int b; logic [31:0] r;
      logic [31:0] old_v, mk, st, nv;
      old_v = 32'hA5A5_1234; mk = 32'h00FF_00F0; st = 32'h0012_0003;
      nv = (old_v & ~mk) | st;
      run_op("modify A1", 2, A1, st, mk, b, r);
      check_eq("R6 five commands", 32'(log_n - b), 32'd5);
      check_cmd("R6 page", b, 5'h18, 5'h00, 1'b0, e_page(A1));
      check_cmd("R6 read low", b + 1, e_phy(A1), e_reg(A1), 1'b1, 16'h0);
      check_cmd("R6 read high", b + 2, e_phy(A1), e_reg(A1) + 5'd1, 1'b1, 16'h0);
      check_cmd("R6 write low", b + 3, e_phy(A1), e_reg(A1), 1'b0, nv[15:0]);
      check_cmd("R6 write high", b + 4, e_phy(A1), e_reg(A1) + 5'd1, 1'b0, nv[31:16]);
      check_eq("R6 old value returned", r, old_v);
      run_op("modify readback", 0, A1, 32'h0, 32'h0, b, r);
      check_eq("R6 merged value", r, nv);
   endtask

   task automatic t_debug();
      int b; logic [31:0] r;
      run_op("debug write", 3, 25'h000_0004, 32'h0012_480C, 32'h0, b, r);
      check_eq("R7 two commands", 32'(log_n - b), 32'd2);
      check_cmd("R7 debug address", b, 5'h04, 5'h1D, 1'b0, 16'h0012);
      check_cmd("R7 debug data", b + 1, 5'h04, 5'h1E, 1'b0, 16'h480C);
      run_op("after debug read", 0, A2, 32'h0, 32'h0, b, r);
      check_eq("R7 cache kept", 32'(log_n - b), 32'd2);
      check_eq("R7 read after debug", r, 32'h0BAD_F00D);
   endtask

   task automatic t_ignore_busy();
      int b, d0; bit got;
      logic [31:0] r;
      b = log_n; d0 = done_cnt; got = 0;
      @(negedge clk);
      host_addr = A2; host_wdata = 32'h1357_9BDF; host_wr = 1;
      @(negedge clk);
      host_wr = 0;
      @(negedge clk);
      host_addr = A3; host_rd = 1;
      @(negedge clk);
      host_rd = 0; host_mod = 1; host_wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      host_mod = 0;
      for (int i = 0; i < 400; i++) begin
         if (host_done) begin got = 1; break; end
         @(negedge clk);
      end
      repeat (40) @(negedge clk);
      check_eq("R10 request seen", 32'(got), 32'd1);
      check_eq("R10 busy strobes ignored cmds", 32'(log_n - b), 32'd2);
      check_eq("R10 busy strobes ignored done", 32'(done_cnt - d0), 32'd1);
      run_op("ignore readback", 0, A2, 32'h0, 32'h0, b, r);
      check_eq("R10 first request data", r, 32'h1357_9BDF);
   endtask

   task automatic t_priority();
      int b, d0; bit got;
      b = log_n; d0 = done_cnt; got = 0;
      @(negedge clk);
      host_addr = A2; host_wdata = 32'h0; host_mask = 32'h0;
      host_rd = 1; host_wr = 1; host_mod = 1; host_dbg = 1;
      @(negedge clk);
      host_rd = 0; host_wr = 0; host_mod = 0; host_dbg = 0;
      for (int i = 0; i < 400; i++) begin
         if (host_done) begin got = 1; break; end
         @(negedge clk);
      end
      check_eq("R10 priority done", 32'(got), 32'd1);
      check_eq("R10 read wins count", 32'(log_n - b), 32'd2);
      check_eq("R10 read wins dir", 32'(log_rd[b]), 32'd1);
      check_eq("R10 read wins value", host_rdata, 32'h1357_9BDF);
      @(negedge clk);
   endtask

   task automatic t_reset_invalidate();
      int b; logic [31:0] r;
      @(negedge clk); rst_n = 0;
      repeat (3) @(negedge clk);
      check_eq("R9 done low in reset", 32'(host_done), 32'd0);
      rst_n = 1;
      @(negedge clk);
      run_op("read after reset", 0, A2, 32'h0, 32'h0, b, r);
      check_eq("R3 reset forces page write", 32'(log_n - b), 32'd3);
      check_cmd("R3 page after reset", b, 5'h18, 5'h00, 1'b0, e_page(A2));
      check_eq("R5 value after reset", r, 32'h1357_9BDF);
   endtask

   task automatic finish_run();
      check_eq("R8 one start per command", 32'(start_cnt), 32'(log_n));
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
            finish_run();
         end
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      t_reset_state();
      rst_n = 1;
      @(negedge clk);
      t_first_write();
      t_cached_write();
      t_read();
      t_new_page();
      t_modify();
      t_debug();
      t_ignore_busy();
      t_priority();
      t_reset_invalidate();
      repeat (5) @(negedge clk);
      finish_run();
   end
endmodule